// File: doc/BRIEF.md
# Multiplexed Common-Line Scan Timing Generator

This block produces the row-scan timing for a multiplexed character display. Every common (COM) line is selected for a fixed number of display clocks. For each selection slot the block reports three things: which text line of the display RAM to fetch, which glyph row of the character font to take, and whether the slot belongs to the icon common. The icon common is one signal that drives two output pins. The block also gives a frame-start pulse, a per-frame toggle used to alternate the drive polarity, and a slow blink phase for cursor and icon blinking.

The scan has two modes. In two-line mode it covers 16 text COM lines plus the icon slot, a 1/17 duty. In three-line mode it covers 24 text COM lines plus the icon slot, a 1/25 duty. The direction input reverses the order in which the text COM lines are stepped. The double-height code lets one region of the panel repeat each glyph row over two COM periods. The line-shift code rotates which display-RAM line appears at the top. Configuration inputs take effect live. Normal use is to set them and then hold them, or to change them under reset.

Sequencer states: `S_TEXT` steps the text COM slots. The transition `TEXT_TO_ICON` is taken at the end of the last text slot. `S_ICON` is the icon slot. The transition `ICON_TO_TEXT` is taken at its end and also closes the frame.

Top module: `com_scan_gen`

## Requirements
- R1: After reset the block is in its first text slot, with frame_start=1, com_idx=first scanned COM, frame_tgl=0 and blink_ph=0.
- R2: Each COM slot, text or icon, lasts exactly CLK_PER_COM (16) clocks, and com_idx is constant within a slot.
- R3: A frame is 16 text slots plus 1 icon slot when line3=0, and 24 plus 1 when line3=1. The icon slot is last. During it icon_act=1 and com_idx=24.
- R4: With com_rev=0 the text slots carry com_idx 0,1,...,L-1. With com_rev=1 they carry L-1,...,0. L is 16 or 24.
- R5: For a normal row at physical COM p, the display line position is p/8 and glyph_row is p%8.
- R6: With dh_code=01, every COM p<16 is a double-height row: line position 0 and glyph_row=p/2. COM p>=16 stays normal.
- R7: With dh_code=10 and line3=1, every COM p>=8 is a double-height row: line position 1 and glyph_row=(p-8)/2. With dh_code=10 and line3=0, and with codes 00 and 11, all rows are normal.
- R8: ram_line equals (line position + shift_code) mod 4.
- R9: frame_start is high for exactly one clock, the first clock of the first text slot of each frame.
- R10: frame_tgl inverts at the start of every frame.
- R11: blink_ph inverts once every BLINK_FRAMES (25) frames, at a frame start.
- R12: During the icon slot ram_line=0 and glyph_row=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line3 | input | 1 | 1 = three-line mode (1/25 duty), 0 = two-line mode (1/17 duty) |
| com_rev | input | 1 | 1 = descending COM order, 0 = ascending |
| dh_code | input | 2 | Double-height region select |
| shift_code | input | 2 | Display-RAM line shown at the top (0..3) |
| com_idx | output | 5 | Active COM index; 24 for the icon common |
| icon_act | output | 1 | Icon common slot active |
| ram_line | output | 2 | Display-RAM text line to fetch |
| glyph_row | output | 3 | Font glyph row to fetch |
| frame_start | output | 1 | One-clock pulse at the start of each frame |
| frame_tgl | output | 1 | Inverts every frame |
| blink_ph | output | 1 | Blink phase, inverts every BLINK_FRAMES frames |

## Verification
The bench sweeps every combination of line mode, direction, double-height code and line shift over a full frame. It compares each clock against arithmetic expectations. This catches an off-by-one end-of-frame test, which would lengthen or shorten the duty, and a reversed order that starts at the wrong COM. It also catches a double-height region applied in two-line mode for code 10, and a line shift that adds before rather than after the double-height folding. The slot length and the icon slot are checked at each boundary, so a 15- or 17-clock slot or a missing icon slot shows up at once. The blink phase is watched across the exact frame where it should invert, so a divider off by one frame is exposed.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;
    typedef enum logic {
        S_TEXT = 1'b0,
        S_ICON = 1'b1
    } scan_state_t;
endpackage

// File: rtl/com_scan_seq.sv
module com_scan_seq
    import com_scan_pkg::*;
#(
    parameter int CLK_PER_COM = 16,
    parameter int COMS_2L     = 16,
    parameter int COMS_3L     = 24,
    parameter int SLOT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line3,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] last_text,
    output logic              icon_act,
    output logic              frame_start,
    output logic              frame_end
);
    localparam int TICK_W = (CLK_PER_COM > 1) ? $clog2(CLK_PER_COM) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLK_PER_COM - 1);

    scan_state_t       state, state_nx;
    logic [TICK_W-1:0] tick, tick_nx;
    logic [SLOT_W-1:0] slot_nx;
    logic              tick_wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_TEXT;
            tick  <= '0;
            slot  <= '0;
        end else begin
            state <= state_nx;
            tick  <= tick_nx;
            slot  <= slot_nx;
        end
    end

    // next state and outputs
    always_comb begin
        last_text   = line3 ? SLOT_W'(COMS_3L - 1) : SLOT_W'(COMS_2L - 1);
        tick_wrap   = (tick == TICK_LAST);
        tick_nx     = tick_wrap ? '0 : tick + 1'b1;
        state_nx    = state;
        slot_nx     = slot;
        icon_act    = 1'b0;
        frame_start = 1'b0;
        frame_end   = 1'b0;
        unique case (state)
            S_TEXT: begin
                frame_start = (slot == '0) && (tick == '0);
                if (tick_wrap) begin
                    if (slot >= last_text) begin   // TEXT_TO_ICON
                        state_nx = S_ICON;
                        slot_nx  = '0;
                    end else begin
                        slot_nx  = slot + 1'b1;
                    end
                end
            end
            S_ICON: begin
                icon_act  = 1'b1;
                frame_end = tick_wrap;
                if (tick_wrap) begin               // ICON_TO_TEXT
                    state_nx = S_TEXT;
                    slot_nx  = '0;
                end
            end
            default: state_nx = S_TEXT;
        endcase
    end
endmodule

// File: rtl/com_row_map.sv
module com_row_map #(
    parameter int ROWS_PER_LINE = 8,
    parameter int SLOT_W        = 5,
    parameter int ROW_W         = 3
) (
    input  logic [SLOT_W-1:0] phys,
    input  logic              line3,
    input  logic [1:0]        dh_code,
    input  logic [1:0]        shift_code,
    output logic [1:0]        ram_line,
    output logic [ROW_W-1:0]  glyph_row
);
    localparam logic [SLOT_W-1:0] ROWS_V = SLOT_W'(ROWS_PER_LINE);
    localparam logic [SLOT_W-1:0] DBL_V  = SLOT_W'(2 * ROWS_PER_LINE);

    logic              dbl_lo, dbl_hi;
    logic [1:0]        pos;
    logic [SLOT_W-1:0] half;

    always_comb begin
        dbl_lo = (dh_code == 2'b01) && (phys < DBL_V);
        dbl_hi = (dh_code == 2'b10) && line3 && (phys >= ROWS_V);
        half   = '0;
        if (dbl_lo) begin
            pos       = 2'd0;
            half      = phys >> 1;
            glyph_row = ROW_W'(half);
        end else if (dbl_hi) begin
            pos       = 2'd1;
            half      = (phys - ROWS_V) >> 1;
            glyph_row = ROW_W'(half);
        end else begin
            pos       = 2'(phys / ROWS_V);
            glyph_row = ROW_W'(phys % ROWS_V);
        end
        ram_line = pos + shift_code;
    end
endmodule

// File: rtl/com_blink_div.sv
module com_blink_div #(
    parameter int BLINK_FRAMES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    output logic frame_tgl,
    output logic blink_ph
);
    localparam int CNT_W = $clog2(BLINK_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_FRAMES - 1);

    logic [CNT_W-1:0] fcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt      <= '0;
            frame_tgl <= 1'b0;
            blink_ph  <= 1'b0;
        end else if (frame_end) begin
            frame_tgl <= ~frame_tgl;
            if (fcnt == CNT_LAST) begin
                fcnt     <= '0;
                blink_ph <= ~blink_ph;
            end else begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/com_scan_gen.sv
module com_scan_gen #(
    parameter int CLK_PER_COM   = 16,
    parameter int ROWS_PER_LINE = 8,
    parameter int COMS_2L       = 16,
    parameter int COMS_3L       = 24,
    parameter int BLINK_FRAMES  = 25,
    localparam int SLOT_W       = $clog2(COMS_3L + 1),
    localparam int ROW_W        = $clog2(ROWS_PER_LINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line3,
    input  logic              com_rev,
    input  logic [1:0]        dh_code,
    input  logic [1:0]        shift_code,
    output logic [SLOT_W-1:0] com_idx,
    output logic              icon_act,
    output logic [1:0]        ram_line,
    output logic [ROW_W-1:0]  glyph_row,
    output logic              frame_start,
    output logic              frame_tgl,
    output logic              blink_ph
);
    localparam logic [SLOT_W-1:0] ICON_IDX = SLOT_W'(COMS_3L);

    logic [SLOT_W-1:0] slot, last_text, phys;
    logic              frame_end;
    logic [1:0]        map_line;
    logic [ROW_W-1:0]  map_row;

    com_scan_seq #(
        .CLK_PER_COM(CLK_PER_COM), .COMS_2L(COMS_2L),
        .COMS_3L(COMS_3L), .SLOT_W(SLOT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .line3(line3),
        .slot(slot), .last_text(last_text), .icon_act(icon_act),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    assign phys = com_rev ? (last_text - slot) : slot;

    com_row_map #(
        .ROWS_PER_LINE(ROWS_PER_LINE), .SLOT_W(SLOT_W), .ROW_W(ROW_W)
    ) u_map (
        .phys(phys), .line3(line3), .dh_code(dh_code),
        .shift_code(shift_code), .ram_line(map_line), .glyph_row(map_row)
    );

    com_blink_div #(.BLINK_FRAMES(BLINK_FRAMES)) u_blink (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
        .frame_tgl(frame_tgl), .blink_ph(blink_ph)
    );

    always_comb begin
        com_idx   = icon_act ? ICON_IDX : phys;
        ram_line  = icon_act ? 2'd0 : map_line;
        glyph_row = icon_act ? '0 : map_row;
    end
endmodule

// File: rtl/com_scan_gen_chk.sv
module com_scan_gen_chk #(
    parameter int CLK_PER_COM = 16,
    parameter int SLOT_W      = 5,
    parameter int ROW_W       = 3,
    parameter int COMS_2L     = 16,
    parameter int COMS_3L     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line3,
    input logic [SLOT_W-1:0] com_idx,
    input logic              icon_act,
    input logic [1:0]        ram_line,
    input logic [ROW_W-1:0]  glyph_row,
    input logic              frame_start,
    input logic              frame_tgl,
    input logic              blink_ph
);
    localparam int CC_W = (CLK_PER_COM > 1) ? $clog2(CLK_PER_COM) : 1;
    logic [CC_W-1:0] cc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cc <= '0;
        else        cc <= (cc == CC_W'(CLK_PER_COM - 1)) ? '0 : cc + 1'b1;
    end

    p_slot_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(com_idx) |-> cc == '0);

    p_text_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !icon_act |-> com_idx < (line3 ? SLOT_W'(COMS_3L) : SLOT_W'(COMS_2L)));

    p_icon_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        icon_act |-> com_idx == SLOT_W'(COMS_3L));

    p_start_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (cc == '0) && !icon_act);

    p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    p_tgl_at_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_tgl) |-> frame_start);

    p_blink_at_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blink_ph) |-> frame_start && !$stable(frame_tgl));

    p_icon_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        icon_act |-> (ram_line == 2'd0) && (glyph_row == '0));
endmodule

bind com_scan_gen com_scan_gen_chk #(
    .CLK_PER_COM(CLK_PER_COM), .SLOT_W(SLOT_W), .ROW_W(ROW_W),
    .COMS_2L(COMS_2L), .COMS_3L(COMS_3L)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line3(line3), .com_idx(com_idx),
    .icon_act(icon_act), .ram_line(ram_line), .glyph_row(glyph_row),
    .frame_start(frame_start), .frame_tgl(frame_tgl), .blink_ph(blink_ph)
);

// File: tb/com_scan_gen_tb.sv
`timescale 1ns/1ps
module com_scan_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line3 = 1'b0;
    logic       com_rev = 1'b0;
    logic [1:0] dh_code = 2'd0;
    logic [1:0] shift_code = 2'd0;
    logic [4:0] com_idx;
    logic       icon_act;
    logic [1:0] ram_line;
    logic [2:0] glyph_row;
    logic       frame_start, frame_tgl, blink_ph;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    com_scan_gen u_dut (
        .clk(clk), .rst_n(rst_n), .line3(line3), .com_rev(com_rev),
        .dh_code(dh_code), .shift_code(shift_code), .com_idx(com_idx),
        .icon_act(icon_act), .ram_line(ram_line), .glyph_row(glyph_row),
        .frame_start(frame_start), .frame_tgl(frame_tgl), .blink_ph(blink_ph)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input bit n, input bit s, input int dh, input int sh);
        @(negedge clk);
        rst_n      = 1'b0;
        line3      = n;
        com_rev    = s;
        dh_code    = 2'(dh);
        shift_code = 2'(sh);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Walks one frame plus one clock and compares every output each clock.
    task automatic sweep(input bit n, input bit s, input int dh, input int sh);
        int len, slots, f, k, p, pos, row, eline;
        bit icon;
        len   = n ? 24 : 16;
        slots = len + 1;
        do_reset(n, s, dh, sh);
        for (int c = 0; c <= 16 * slots; c++) begin
            f    = c % (16 * slots);
            k    = f / 16;
            icon = (k == len);
            p    = icon ? 24 : (s ? len - 1 - k : k);
            if (icon) begin
                pos = 0; row = 0;
            end else if (dh == 1 && p < 16) begin
                pos = 0; row = p / 2;
            end else if (dh == 2 && n && p >= 8) begin
                pos = 1; row = (p - 8) / 2;
            end else begin
                pos = p / 8; row = p % 8;
            end
            eline = icon ? 0 : (pos + sh) % 4;
            if (icon) begin
                chk(com_idx == 5'(p) && icon_act, "R3 icon slot", com_idx, p);
            end else if (f % 16 == 0) begin
                chk(com_idx == 5'(p) && !icon_act, "R4 com order", com_idx, p);
            end else begin
                chk(com_idx == 5'(p), "R2 slot hold", com_idx, p);
            end
            if (icon)
                chk(glyph_row == 3'(row), "R12 icon row", glyph_row, row);
            else if (dh == 1)
                chk(glyph_row == 3'(row), "R6 dbl low row", glyph_row, row);
            else if (dh == 2)
                chk(glyph_row == 3'(row), "R7 dbl high row", glyph_row, row);
            else
                chk(glyph_row == 3'(row), "R5 normal row", glyph_row, row);
            chk(ram_line == 2'(eline), "R8 ram line", ram_line, eline);
            chk(frame_start == (f == 0), "R9 frame start", frame_start, f == 0);
            chk(frame_tgl == (c >= 16 * slots), "R10 frame toggle", frame_tgl, c >= 16 * slots);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(1'b0, 1'b1, 0, 0);
        chk(frame_start == 1'b1, "R1 start", frame_start, 1);
        chk(com_idx == 5'd15, "R1 first com", com_idx, 15);
        chk(frame_tgl == 1'b0, "R1 toggle", frame_tgl, 0);
        chk(blink_ph == 1'b0, "R1 blink", blink_ph, 0);

        for (int n = 0; n < 2; n++)
            for (int s = 0; s < 2; s++)
                for (int dh = 0; dh < 4; dh++)
                    for (int sh = 0; sh < 4; sh++)
                        sweep(n[0], s[0], dh, sh);

        // R11 blink phase every 25 frames (two-line: 272 clocks a frame)
        do_reset(1'b0, 1'b0, 0, 0);
        for (int c = 0; c <= 13600; c++) begin
            if (c == 6799) chk(blink_ph == 1'b0, "R11 before", blink_ph, 0);
            if (c == 6800) chk(blink_ph == 1'b1, "R11 first flip", blink_ph, 1);
            if (c == 13599) chk(blink_ph == 1'b1, "R11 hold", blink_ph, 1);
            if (c == 13600) chk(blink_ph == 1'b0, "R11 second flip", blink_ph, 0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule